// File: doc/BRIEF.md
# Five-Source Priority Interrupt Controller

This block collects five hardware interrupt request lines and presents at most one of them to the processor core at a time, together with a 16-bit vector address for the selected source. Each line has its own trigger behaviour. The non-maskable line needs a rising edge followed by a sustained high level. The high restart line latches a rising edge, so a short pulse is held until it is served. Two middle lines are level-sensitive. The general request line is level-sensitive and is not individually maskable.

Software controls the block in three ways. It sets and clears a global enable flip-flop with two strobes. It updates per-source masks through a mask write, which can also discard a latched edge. It reads a status word that holds the masks, the enable and the raw pending state. The core accepts the presented request by pulsing an acknowledge. A wake output tells a halted core to resume after reset or while a request is being presented.

All request pins pass through a parameterised sampling stage. The default has one stage, and the latencies below assume that default. Source indices, from highest to lowest priority, are: 0 non-maskable, 1 latched edge, 2 level A, 3 level B, 4 general.

Top module: `irq_prio5`

## Requirements
- R1: When several sources are eligible, `irq_o` presents only the highest-priority one, in the order non-maskable, latched edge, level A, level B, general. A lower source that loses stays pending: an edge stays latched, and a level source is served while its line is still high.
- R2: The vector is half of STEP (8) times the doubled restart number: non-maskable 0x0024, latched edge 0x003C, level A 0x0034, level B 0x002C. The general source presents EXT_VEC, which defaults to 0x0000.
- R3: The non-maskable source is presented only after a sampled rising edge, and only while the line is still high on the following edge. A pulse lasting one clock is never presented. The source ignores the enable flip-flop and all masks. After it is accepted it is not presented again until a new rising edge.
- R4: A rising edge on the latched-edge line sets its latch even while that source is masked or disabled. The latch holds until the source is accepted, or until a mask write is made with `edge_clr_i`=1.
- R5: Level A and level B are eligible only while their line is high, their mask bit is 0 and the enable flip-flop is 1.
- R6: The general source is eligible while its line is high and the enable flip-flop is 1, whatever the mask bits.
- R7: `ien_set_i` sets the enable flip-flop and `ien_clr_i` clears it. The clear wins if both are given together. Accepting a request (`ack_i` while `irq_o` is 1) clears it. `ack_i` while `irq_o` is 0 has no effect.
- R8: A mask write (`mask_wr_i`) with `mask_upd_i`=1 loads `mask_bits_i`, where bit 0 masks level B, bit 1 masks level A and bit 2 masks the latched edge (1 = masked). With `mask_upd_i`=0 the masks stay unchanged.
- R9: After reset all three masks are 1, the enable flip-flop is 0, no latch is set and `irq_o` is 0.
- R10: `status_o` bits 2:0 hold the masks (same positions as R8). Bit 3 holds the enable flip-flop. Bits 4, 5, 6 and 7 hold the raw pending state of level B, level A, the latched edge and the non-maskable source.
- R11: `wake_o` is 1 in the first cycle after reset is released and in every cycle in which `irq_o` is 1.
- R12: A level or general line is presented one sampling edge after it rises. The latched edge and the non-maskable source are presented two edges after they rise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| nmi_req_i | input | 1 | Non-maskable request line |
| edge_req_i | input | 1 | Latched rising-edge request line |
| lvla_req_i | input | 1 | Level A request line |
| lvlb_req_i | input | 1 | Level B request line |
| ext_req_i | input | 1 | General level request line |
| ien_set_i | input | 1 | Enable flip-flop set strobe |
| ien_clr_i | input | 1 | Enable flip-flop clear strobe |
| mask_wr_i | input | 1 | Mask write strobe |
| mask_upd_i | input | 1 | Mask write applies `mask_bits_i` when 1 |
| mask_bits_i | input | 3 | New mask values (bit0 level B, bit1 level A, bit2 edge) |
| edge_clr_i | input | 1 | With `mask_wr_i`, discards the edge latch |
| ack_i | input | 1 | Core accepts the presented request |
| irq_o | output | 1 | A request is presented |
| vec_o | output | VEC_W | Vector of the presented source |
| status_o | output | 8 | Masks, enable and raw pending bits |
| wake_o | output | 1 | Resume signal for a halted core |

## Verification
The request pins go through one sampling register. A level or general request therefore appears on `irq_o` and `vec_o` right after the first rising clock edge that sees the pin high. The latched edge and the non-maskable source appear after the second edge. Strobes, mask writes and acknowledges change `status_o` and `irq_o` right after the edge that samples them. The bench drives every input 1 ns after a rising edge, counts the edges each result needs, and samples at that same point after exactly that count. It also checks that the results are still absent one edge too early.

// File: rtl/irqp_pkg.sv
package irqp_pkg;

   localparam int NSRC = 5;
   localparam int NMSK = 3;

   localparam int SRC_NMI  = 0;
   localparam int SRC_EDGE = 1;
   localparam int SRC_LVLA = 2;
   localparam int SRC_LVLB = 3;
   localparam int SRC_EXT  = 4;

   typedef enum logic [1:0] {
      TRG_LEVEL      = 2'd0,
      TRG_RISE_LATCH = 2'd1,
      TRG_RISE_HOLD  = 2'd2
   } trig_e;

   function automatic trig_e src_trig(input int idx);
      case (idx)
         SRC_NMI:  return TRG_RISE_HOLD;
         SRC_EDGE: return TRG_RISE_LATCH;
         default:  return TRG_LEVEL;
      endcase
   endfunction

   // restart number times two, so half steps stay integral
   function automatic int src_half_rst(input int idx);
      case (idx)
         SRC_NMI:  return 9;
         SRC_EDGE: return 15;
         SRC_LVLA: return 13;
         SRC_LVLB: return 11;
         default:  return 0;
      endcase
   endfunction

   function automatic bit src_gated(input int idx);
      return idx != SRC_NMI;
   endfunction

   // slot in the mask register, -1 when the source has no mask
   function automatic int src_mask_slot(input int idx);
      case (idx)
         SRC_EDGE: return 2;
         SRC_LVLA: return 1;
         SRC_LVLB: return 0;
         default:  return -1;
      endcase
   endfunction

   function automatic logic [31:0] src_vector(input int idx, input int step,
                                              input logic [31:0] ext_vec);
      if (idx == SRC_EXT) return ext_vec;
      return 32'(src_half_rst(idx) * step / 2);
   endfunction

endpackage

// File: rtl/irqp_sync.sv
module irqp_sync #(
   parameter int W      = 5,
   parameter int STAGES = 1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] raw_i,
   output logic [W-1:0] cur_o,
   output logic [W-1:0] prv_o
);

   logic [W-1:0] stage_q [STAGES+1];

   genvar k;
   generate
      for (k = 0; k <= STAGES; k++) begin : g_stage
         if (k == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[k] <= '0;
               else        stage_q[k] <= raw_i;
            end
         end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
               if (!rst_n) stage_q[k] <= '0;
               else        stage_q[k] <= stage_q[k-1];
            end
         end
      end
   endgenerate

   assign cur_o = stage_q[STAGES-1];
   assign prv_o = stage_q[STAGES];

endmodule

// File: rtl/irqp_trig.sv
module irqp_trig
   import irqp_pkg::*;
#(
   parameter trig_e MODE = TRG_LEVEL
) (
   input  logic clk,
   input  logic rst_n,
   input  logic lvl_i,
   input  logic prv_i,
   input  logic clr_i,
   output logic pend_o
);

   logic rise;
   assign rise = lvl_i & ~prv_i;

   generate
      if (MODE == TRG_RISE_LATCH) begin : g_latch
         logic held_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     held_q <= 1'b0;
            else if (rise)  held_q <= 1'b1;
            else if (clr_i) held_q <= 1'b0;
         end
         assign pend_o = held_q;
      end else if (MODE == TRG_RISE_HOLD) begin : g_hold
         logic arm_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               arm_q <= 1'b0;
            else if (rise)            arm_q <= 1'b1;
            else if (!lvl_i || clr_i) arm_q <= 1'b0;
         end
         assign pend_o = arm_q & lvl_i;
      end else begin : g_level
         logic unused_lvl;
         assign unused_lvl = ^{clk, rst_n, rise, clr_i};
         assign pend_o     = lvl_i;
      end
   endgenerate

endmodule

// File: rtl/irqp_ctl.sv
module irqp_ctl #(
   parameter int NMSK = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            ien_set_i,
   input  logic            ien_clr_i,
   input  logic            take_i,
   input  logic            mask_wr_i,
   input  logic            mask_upd_i,
   input  logic [NMSK-1:0] mask_bits_i,
   output logic            ien_o,
   output logic [NMSK-1:0] mask_o
);

   logic            ien_q;
   logic [NMSK-1:0] mask_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     ien_q <= 1'b0;
      else if (ien_clr_i || take_i)   ien_q <= 1'b0;
      else if (ien_set_i)             ien_q <= 1'b1;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                        mask_q <= '1;
      else if (mask_wr_i && mask_upd_i)  mask_q <= mask_bits_i;
   end

   assign ien_o  = ien_q;
   assign mask_o = mask_q;

endmodule

// File: rtl/irqp_sel.sv
module irqp_sel
   import irqp_pkg::*;
#(
   parameter int               N       = 5,
   parameter int               VEC_W   = 16,
   parameter int               STEP    = 8,
   parameter logic [VEC_W-1:0] EXT_VEC = '0
) (
   input  logic [N-1:0]     elig_i,
   output logic             any_o,
   output logic [N-1:0]     win_o,
   output logic [VEC_W-1:0] vec_o
);

   logic [VEC_W-1:0] vtab [N];

   genvar g;
   generate
      for (g = 0; g < N; g++) begin : g_vec
         localparam logic [31:0] VFULL = src_vector(g, STEP, 32'(EXT_VEC));
         assign vtab[g] = VFULL[VEC_W-1:0];
      end
   endgenerate

   // lowest index is highest priority: scan upward from the bottom
   always_comb begin
      win_o = '0;
      vec_o = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (elig_i[i]) begin
            win_o    = '0;
            win_o[i] = 1'b1;
            vec_o    = vtab[i];
         end
      end
   end

   assign any_o = |elig_i;

endmodule

// File: rtl/irq_prio5.sv
module irq_prio5
   import irqp_pkg::*;
#(
   parameter int               VEC_W       = 16,
   parameter int               STEP        = 8,
   parameter int               SYNC_STAGES = 1,
   parameter logic [VEC_W-1:0] EXT_VEC     = '0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              nmi_req_i,
   input  logic              edge_req_i,
   input  logic              lvla_req_i,
   input  logic              lvlb_req_i,
   input  logic              ext_req_i,
   input  logic              ien_set_i,
   input  logic              ien_clr_i,
   input  logic              mask_wr_i,
   input  logic              mask_upd_i,
   input  logic [NMSK-1:0]   mask_bits_i,
   input  logic              edge_clr_i,
   input  logic              ack_i,
   output logic              irq_o,
   output logic [VEC_W-1:0]  vec_o,
   output logic [2*NMSK+1:0] status_o,
   output logic              wake_o
);

   localparam int MAX_VEC = 15 * STEP / 2;

   generate
      if (VEC_W < 8) begin : g_bad_vw
         $error("irq_prio5: VEC_W must be at least 8");
      end
      if (SYNC_STAGES < 1) begin : g_bad_sync
         $error("irq_prio5: SYNC_STAGES must be at least 1");
      end
      if (STEP < 2 || (STEP % 2) != 0) begin : g_bad_step
         $error("irq_prio5: STEP must be even and at least 2");
      end
      if (VEC_W < 31 && MAX_VEC >= (1 << VEC_W)) begin : g_bad_fit
         $error("irq_prio5: vectors do not fit in VEC_W");
      end
   endgenerate

   logic [NSRC-1:0] raw, s_cur, s_prv;
   logic [NSRC-1:0] pend, elig, win, clr, mbit, gbit;
   logic [NMSK-1:0] mask_q;
   logic            ien_q, any, take, boot_q;

   assign raw = {ext_req_i, lvlb_req_i, lvla_req_i, edge_req_i, nmi_req_i};

   irqp_sync #(.W(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .raw_i (raw),
      .cur_o (s_cur),
      .prv_o (s_prv)
   );

   irqp_ctl #(.NMSK(NMSK)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .ien_set_i   (ien_set_i),
      .ien_clr_i   (ien_clr_i),
      .take_i      (take),
      .mask_wr_i   (mask_wr_i),
      .mask_upd_i  (mask_upd_i),
      .mask_bits_i (mask_bits_i),
      .ien_o       (ien_q),
      .mask_o      (mask_q)
   );

   genvar g;
   generate
      for (g = 0; g < NSRC; g++) begin : g_src
         localparam trig_e MODE = src_trig(g);
         localparam int    SLOT = src_mask_slot(g);

         if (MODE == TRG_RISE_LATCH) begin : g_clr_latch
            assign clr[g] = (take & win[g]) | (mask_wr_i & edge_clr_i);
         end else begin : g_clr_take
            assign clr[g] = take & win[g];
         end

         irqp_trig #(.MODE(MODE)) u_trig (
            .clk    (clk),
            .rst_n  (rst_n),
            .lvl_i  (s_cur[g]),
            .prv_i  (s_prv[g]),
            .clr_i  (clr[g]),
            .pend_o (pend[g])
         );

         if (SLOT >= 0) begin : g_masked
            assign mbit[g] = mask_q[SLOT];
         end else begin : g_unmasked
            assign mbit[g] = 1'b0;
         end

         if (src_gated(g)) begin : g_gated
            assign gbit[g] = ien_q;
         end else begin : g_free
            assign gbit[g] = 1'b1;
         end

         assign elig[g] = pend[g] & gbit[g] & ~mbit[g];
      end
   endgenerate

   irqp_sel #(.N(NSRC), .VEC_W(VEC_W), .STEP(STEP), .EXT_VEC(EXT_VEC)) u_sel (
      .elig_i (elig),
      .any_o  (any),
      .win_o  (win),
      .vec_o  (vec_o)
   );

   assign take = ack_i & any;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) boot_q <= 1'b1;
      else        boot_q <= 1'b0;
   end

   assign irq_o    = any;
   assign wake_o   = any | boot_q;
   assign status_o = {pend[SRC_NMI], pend[SRC_EDGE], pend[SRC_LVLA], pend[SRC_LVLB],
                      ien_q, mask_q};

endmodule

// File: rtl/irqp_chk.sv
module irqp_chk
   import irqp_pkg::*;
#(
   parameter int VEC_W = 16,
   parameter int STEP  = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              ack_i,
   input logic              mask_wr_i,
   input logic              mask_upd_i,
   input logic              edge_clr_i,
   input logic [NMSK-1:0]   mask_bits_i,
   input logic              irq_o,
   input logic [VEC_W-1:0]  vec_o,
   input logic [2*NMSK+1:0] status_o,
   input logic              wake_o
);

   localparam logic [31:0] V_NMI_F  = src_vector(SRC_NMI, STEP, 32'd0);
   localparam logic [31:0] V_EDGE_F = src_vector(SRC_EDGE, STEP, 32'd0);
   localparam logic [VEC_W-1:0] V_NMI  = V_NMI_F[VEC_W-1:0];
   localparam logic [VEC_W-1:0] V_EDGE = V_EDGE_F[VEC_W-1:0];

   p_nmi_wins_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && status_o[7]) |-> vec_o == V_NMI);

   p_only_nmi_when_off_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_o && !status_o[3]) |-> vec_o == V_NMI);

   p_edge_latch_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (status_o[6] && !(ack_i && irq_o && vec_o == V_EDGE) && !(mask_wr_i && edge_clr_i))
      |=> status_o[6]);

   p_take_clears_ien_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (ack_i && irq_o) |=> !status_o[3]);

   p_mask_load_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (mask_wr_i && mask_upd_i) |=> status_o[2:0] == $past(mask_bits_i));

   p_mask_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
      !(mask_wr_i && mask_upd_i) |=> $stable(status_o[2:0]));

   p_wake_follows_r11: assert property (@(posedge clk) disable iff (!rst_n)
      irq_o |-> wake_o);

endmodule

bind irq_prio5 irqp_chk #(.VEC_W(VEC_W), .STEP(STEP)) u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .ack_i       (ack_i),
   .mask_wr_i   (mask_wr_i),
   .mask_upd_i  (mask_upd_i),
   .edge_clr_i  (edge_clr_i),
   .mask_bits_i (mask_bits_i),
   .irq_o       (irq_o),
   .vec_o       (vec_o),
   .status_o    (status_o),
   .wake_o      (wake_o)
);

// File: tb/tb_irq_prio5.sv
`timescale 1ns/1ps
module tb_irq_prio5;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        nmi_req_i = 0, edge_req_i = 0, lvla_req_i = 0, lvlb_req_i = 0, ext_req_i = 0;
   logic        ien_set_i = 0, ien_clr_i = 0, mask_wr_i = 0, mask_upd_i = 0, edge_clr_i = 0;
   logic [2:0]  mask_bits_i = '0;
   logic        ack_i = 0;
   logic        irq_o, wake_o;
   logic [15:0] vec_o;
   logic [7:0]  status_o;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #2.5 clk = ~clk;

   irq_prio5 dut (
      .clk(clk), .rst_n(rst_n),
      .nmi_req_i(nmi_req_i), .edge_req_i(edge_req_i), .lvla_req_i(lvla_req_i),
      .lvlb_req_i(lvlb_req_i), .ext_req_i(ext_req_i),
      .ien_set_i(ien_set_i), .ien_clr_i(ien_clr_i),
      .mask_wr_i(mask_wr_i), .mask_upd_i(mask_upd_i), .mask_bits_i(mask_bits_i),
      .edge_clr_i(edge_clr_i), .ack_i(ack_i),
      .irq_o(irq_o), .vec_o(vec_o), .status_o(status_o), .wake_o(wake_o)
   );

   task automatic tick(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic ien_on();
      ien_set_i = 1; tick(1); ien_set_i = 0;
   endtask

   task automatic ien_off();
      ien_clr_i = 1; tick(1); ien_clr_i = 0;
   endtask

   task automatic mask_write(input logic upd, input logic [2:0] bits, input logic eclr);
      mask_wr_i = 1; mask_upd_i = upd; mask_bits_i = bits; edge_clr_i = eclr;
      tick(1);
      mask_wr_i = 0; mask_upd_i = 0; edge_clr_i = 0;
   endtask

   task automatic pulse_ack();
      ack_i = 1; tick(1); ack_i = 0;
   endtask

   task automatic t_reset();
      tick(3);
      rst_n = 1;
      chk("R9", "irq after reset", 32'(irq_o), 32'd0);
      chk("R9", "status after reset", 32'(status_o), 32'h07);
      chk("R11", "wake after reset", 32'(wake_o), 32'd1);
      tick(1);
      chk("R11", "wake one cycle later", 32'(wake_o), 32'd0);
   endtask

   task automatic t_level();
      ien_on();
      lvla_req_i = 1; tick(1);
      chk("R5", "masked level A", 32'(irq_o), 32'd0);
      chk("R10", "level A raw pending bit5", 32'(status_o[5]), 32'd1);
      mask_write(1, 3'b000, 0);
      chk("R5", "unmasked level A irq", 32'(irq_o), 32'd1);
      chk("R2", "level A vector", 32'(vec_o), 32'h0034);
      chk("R11", "wake while presenting", 32'(wake_o), 32'd1);
      lvla_req_i = 0; tick(1);
      chk("R5", "level A dropped", 32'(irq_o), 32'd0);
      lvlb_req_i = 1; tick(1);
      chk("R12", "level B after one edge", 32'(irq_o), 32'd1);
      chk("R2", "level B vector", 32'(vec_o), 32'h002C);
      ien_off();
      chk("R7", "disabled level B", 32'(irq_o), 32'd0);
      chk("R7", "enable bit cleared", 32'(status_o[3]), 32'd0);
      lvlb_req_i = 0; tick(1);
   endtask

   task automatic t_prio();
      mask_write(1, 3'b111, 0);
      ien_on();
      ext_req_i = 1; tick(1);
      chk("R6", "general ignores masks", 32'(irq_o), 32'd1);
      chk("R2", "general vector", 32'(vec_o), 32'h0000);
      lvla_req_i = 1; lvlb_req_i = 1;
      mask_write(1, 3'b000, 0);
      chk("R1", "level A beats B and general", 32'(vec_o), 32'h0034);
      lvla_req_i = 0; tick(1);
      chk("R1", "level B next", 32'(vec_o), 32'h002C);
      lvlb_req_i = 0; tick(1);
      chk("R1", "general last", 32'(vec_o), 32'h0000);
      ext_req_i = 0; tick(1);
      chk("R6", "general dropped", 32'(irq_o), 32'd0);
   endtask

   task automatic t_edge();
      mask_write(1, 3'b100, 0);
      edge_req_i = 1; tick(1); edge_req_i = 0; tick(1);
      chk("R4", "short pulse latched", 32'(status_o[6]), 32'd1);
      chk("R4", "masked edge not presented", 32'(irq_o), 32'd0);
      tick(3);
      chk("R4", "latch holds", 32'(status_o[6]), 32'd1);
      mask_write(1, 3'b000, 0);
      chk("R4", "unmasked edge irq", 32'(irq_o), 32'd1);
      chk("R2", "edge vector", 32'(vec_o), 32'h003C);
      pulse_ack();
      chk("R4", "accept clears latch", 32'(status_o[6]), 32'd0);
      chk("R7", "accept clears enable", 32'(status_o[3]), 32'd0);
      chk("R4", "no irq after accept", 32'(irq_o), 32'd0);
      ien_on();
      edge_req_i = 1; tick(1);
      chk("R12", "edge not yet after one edge", 32'(irq_o), 32'd0);
      tick(1);
      chk("R12", "edge after two edges", 32'(irq_o), 32'd1);
      edge_req_i = 0;
      mask_write(0, 3'b111, 1);
      chk("R4", "mask write clears latch", 32'(status_o[6]), 32'd0);
      chk("R4", "no irq after latch clear", 32'(irq_o), 32'd0);
      chk("R8", "masks kept without update", 32'(status_o[2:0]), 32'd0);
      tick(1);
   endtask

   task automatic t_nmi();
      ien_off();
      mask_write(1, 3'b111, 0);
      chk("R8", "masks loaded", 32'(status_o[2:0]), 32'h7);
      nmi_req_i = 1; tick(1); nmi_req_i = 0; tick(1);
      chk("R3", "one-cycle pulse ignored", 32'(irq_o), 32'd0);
      tick(1);
      chk("R3", "one-cycle pulse still ignored", 32'(irq_o), 32'd0);
      nmi_req_i = 1; tick(1);
      chk("R3", "not yet after one edge", 32'(irq_o), 32'd0);
      tick(1);
      chk("R3", "held line presented while disabled", 32'(irq_o), 32'd1);
      chk("R2", "non-maskable vector", 32'(vec_o), 32'h0024);
      chk("R10", "non-maskable pending bit7", 32'(status_o[7]), 32'd1);
      pulse_ack();
      chk("R3", "no refire after accept", 32'(irq_o), 32'd0);
      tick(3);
      chk("R3", "still no refire with line high", 32'(irq_o), 32'd0);
      nmi_req_i = 0; tick(2);
      mask_write(1, 3'b000, 0);
      ien_on();
      nmi_req_i = 1; edge_req_i = 1; tick(2);
      chk("R1", "non-maskable beats edge", 32'(vec_o), 32'h0024);
      pulse_ack();
      chk("R1", "enable cleared by accept", 32'(irq_o), 32'd0);
      chk("R1", "edge stays latched", 32'(status_o[6]), 32'd1);
      ien_on();
      chk("R1", "edge served next", 32'(vec_o), 32'h003C);
      pulse_ack();
      nmi_req_i = 0; edge_req_i = 0; tick(2);
   endtask

   task automatic t_ien();
      ien_set_i = 1; ien_clr_i = 1; tick(1); ien_set_i = 0; ien_clr_i = 0;
      chk("R7", "clear wins over set", 32'(status_o[3]), 32'd0);
      ien_on();
      chk("R7", "set strobe", 32'(status_o[3]), 32'd1);
      pulse_ack();
      chk("R7", "ack without irq ignored", 32'(status_o[3]), 32'd1);
      ien_off();
   endtask

   initial begin
      t_reset();
      t_level();
      t_prio();
      t_edge();
      t_nmi();
      t_ien();
      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual=timeout expected=completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

endmodule